// File: doc/BRIEF.md
# Fractional-Predivide Programmable Clock Divider

The block produces a gated peripheral clock, for example a pixel clock, from one of three sources: a crystal reference and two PLL outputs. The three sources arrive as edge strobes in the core clock domain: each bit of `src_edge` pulses for one core cycle at every rising and every falling edge of its source. Counting both edges gives half-cycle resolution, so the predivider can divide by 2, 2.5 or 3 source cycles (4, 5 or 6 edges). An integer divider of 2 to 127 follows it. The output is registered in the core domain.

Software writes one 16-bit word through a single-cycle write port. The word carries the source selects, the predivider code, the divider value and an enable. A new word is held in a staging register. It becomes active only when the current output period ends, so no output period is ever cut short. `cfg_valid` reports whether the staged word holds a legal predivider code and divider value.

Top module: `pdclk_gen`

## Requirements
- R1: After reset `clk_out` and `cfg_valid` are 0, and the staged word is all zeros.
- R2: A write with `wr_en` high replaces the whole staged word. Divider value in bits [6:0], predivider code in bits [9:8], PLL choice in bit 13, PLL-vs-crystal select in bit 14, enable in bit 15. No field of an earlier word survives a later write.
- R3: Bit 14 = 0 selects source 0 (crystal) whatever bit 13 holds. Bit 14 = 1 selects source 1 when bit 13 = 0 and source 2 when bit 13 = 1.
- R4: Predivider codes 1, 2 and 3 divide by 2, 2.5 and 3 source cycles (4, 5 and 6 source edges).
- R5: The output period is (predivide ratio × divider value) source cycles. The output is high for floor(divider/2) × ratio source cycles at the start of each period.
- R6: Predivider code 0 or a divider value below 2 clears `cfg_valid`. It also holds `clk_out` low once any high phase in progress has finished.
- R7: A new word written while the output runs takes effect only at the end of the current output period.
- R8: Clearing the enable lets the current high phase finish, then holds `clk_out` low.
- R9: No high pulse on `clk_out` is shorter than two core cycles.
- R10: The full divider range up to 127 is supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 16 | Configuration word (layout in R2) |
| src_edge | input | 3 | Per-source strobes, one per source edge (0 crystal, 1 and 2 PLLs) |
| clk_out | output | 1 | Divided, gated output clock |
| cfg_valid | output | 1 | Staged word holds a legal code and divider value |

## Verification
The assertions check, on every cycle, that the active setting changes only with the divider count at zero. They check that the counters stay inside the active ranges and that no high pulse is shorter than two cycles. They also check that a disabled or invalid setting never raises a low output. Only the bench scenarios can show the exact ratios: they measure the high time and the period for each predivider code, for each source, and at the top of the divider range. The scenarios also show that a word written mid-period leaves the running period intact, and that a disable or an invalid word lets the high phase finish first.

// File: rtl/pdclk_pkg.sv
package pdclk_pkg;
  localparam int WORD_W   = 16;
  localparam int DIV_W    = 7;
  localparam int PRE_W    = 2;
  localparam int PCNT_W   = 3;
  localparam int NSRC     = 3;
  localparam int SEL_W    = $clog2(NSRC);
  localparam int F_PRE    = 8;
  localparam int F_PSEL   = 13;
  localparam int F_ESEL   = 14;
  localparam int F_EN     = 15;

  typedef struct packed {
    logic             en;
    logic             esel;
    logic             psel;
    logic [PRE_W-1:0] pre;
    logic [DIV_W-1:0] div;
  } cfg_t;

  function automatic cfg_t unpack_word(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.en   = w[F_EN];
    c.esel = w[F_ESEL];
    c.psel = w[F_PSEL];
    c.pre  = w[F_PRE +: PRE_W];
    c.div  = w[DIV_W-1:0];
    return c;
  endfunction

  function automatic logic cfg_ok(input cfg_t c);
    return (c.pre != '0) && (c.div >= DIV_W'(2));
  endfunction

  // source edges consumed per predivided tick: code 1/2/3 -> 4/5/6
  function automatic logic [PCNT_W-1:0] pre_edges(input logic [PRE_W-1:0] code);
    return PCNT_W'(code) + PCNT_W'(3);
  endfunction

  function automatic logic [DIV_W-1:0] high_len(input logic [DIV_W-1:0] d);
    return d >> 1;
  endfunction

  function automatic logic [SEL_W-1:0] src_index(input logic esel, input logic psel);
    if (!esel) return SEL_W'(0);
    return psel ? SEL_W'(2) : SEL_W'(1);
  endfunction
endpackage

// File: rtl/pdclk_cfg_stage.sv
module pdclk_cfg_stage
  import pdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output cfg_t              stg,
  output logic              stg_ok
);
  always_ff @(posedge clk) begin
    if (rst)        stg <= '0;
    else if (wr_en) stg <= unpack_word(wr_data);
  end

  assign stg_ok = cfg_ok(stg);

  // R2: a write lands whole in the staging register
  a_r2_write_whole: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (stg == unpack_word($past(wr_data))));
endmodule

// File: rtl/pdclk_edge_mux.sv
module pdclk_edge_mux
  import pdclk_pkg::*;
(
  input  logic [NSRC-1:0]  src_edge,
  input  logic [SEL_W-1:0] sel,
  output logic             edge_o
);
  logic [NSRC-1:0] hit;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign hit[g] = src_edge[g] && (sel == SEL_W'(g));
  end

  assign edge_o = |hit;
endmodule

// File: rtl/pdclk_prediv.sv
module pdclk_prediv
  import pdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             edge_i,
  input  logic [PRE_W-1:0] pre_code,
  output logic             tick
);
  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W-1:0] pe;
  logic              last;

  assign pe   = pre_edges(pre_code);
  assign last = (pcnt == pe - PCNT_W'(1));
  assign tick = !clr && edge_i && last;

  always_ff @(posedge clk) begin
    if (rst || clr)  pcnt <= '0;
    else if (edge_i) pcnt <= last ? '0 : pcnt + PCNT_W'(1);
  end

  // R4: edge count stays below the active ratio in edges
  a_r4_pcnt_range: assert property (@(posedge clk) disable iff (rst)
    !clr |-> (pcnt < pe));
endmodule

// File: rtl/pdclk_gen.sv
module pdclk_gen
  import pdclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [NSRC-1:0]   src_edge,
  output logic              clk_out,
  output logic              cfg_valid
);
  cfg_t             stg, act_q, act_n;
  logic             stg_ok, go;
  logic             run_q, run_n;
  logic [DIV_W-1:0] dcnt_q, dcnt_n;
  logic             src_edge_sel, pre_tick;
  logic             period_end, stop_now;

  pdclk_cfg_stage u_stage (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .stg(stg), .stg_ok(stg_ok)
  );

  pdclk_edge_mux u_mux (
    .src_edge(src_edge), .sel(src_index(act_q.esel, act_q.psel)),
    .edge_o(src_edge_sel)
  );

  pdclk_prediv u_pre (
    .clk(clk), .rst(rst), .clr(!run_q), .edge_i(src_edge_sel),
    .pre_code(act_q.pre), .tick(pre_tick)
  );

  assign cfg_valid  = stg_ok;
  assign go         = stg_ok && stg.en;
  assign period_end = pre_tick && (dcnt_q == act_q.div - DIV_W'(1));
  assign stop_now   = run_q && !go && (dcnt_q >= high_len(act_q.div));

  always_comb begin
    run_n  = run_q;
    dcnt_n = dcnt_q;
    act_n  = act_q;
    if (!run_q) begin
      if (go) begin
        run_n  = 1'b1;
        act_n  = stg;
        dcnt_n = '0;
      end
    end else if (stop_now) begin
      run_n  = 1'b0;
      dcnt_n = '0;
    end else if (pre_tick) begin
      if (period_end) begin
        dcnt_n = '0;
        act_n  = stg;
      end else begin
        dcnt_n = dcnt_q + DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      dcnt_q  <= '0;
      act_q   <= '0;
      clk_out <= 1'b0;
    end else begin
      run_q   <= run_n;
      dcnt_q  <= dcnt_n;
      act_q   <= act_n;
      clk_out <= run_n && (dcnt_n < high_len(act_n.div));
    end
  end

  // R7: the active setting only changes at a period start
  a_r7_switch_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && (act_q != $past(act_q))) |-> (dcnt_q == '0));
  // R5: divider count within the active divider value
  a_r5_dcnt_range: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (dcnt_q < act_q.div));
  // R9: no single-cycle high pulse
  a_r9_no_runt: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_out) |=> clk_out);
  // R6: an invalid staged word never raises a low output
  a_r6_invalid_low: assert property (@(posedge clk) disable iff (rst)
    (!cfg_valid && !clk_out) |=> !clk_out);
  // R8: a cleared enable never raises a low output
  a_r8_disabled_low: assert property (@(posedge clk) disable iff (rst)
    (!stg.en && !clk_out) |=> !clk_out);
endmodule

// File: tb/pdclk_gen_bench.sv
module pdclk_gen_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [2:0]  src_edge = '0;
  logic        clk_out, cfg_valid;
  int          errors = 0;
  int          checks = 0;

  pdclk_gen u_pdclk_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .src_edge(src_edge), .clk_out(clk_out), .cfg_valid(cfg_valid)
  );

  always #2.5 clk = ~clk;

  // source 0 every core cycle, source 1 every 2nd, source 2 every 3rd
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      src_edge[0] = 1'b1;
      src_edge[1] = (n % 2) == 0;
      src_edge[2] = (n % 3) == 0;
      n++;
    end
  end

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  function automatic logic [15:0] word(input logic en, input logic esel, input logic psel,
                                       input int pre, input int dv);
    logic [15:0] w = '0;
    w[15] = en; w[14] = esel; w[13] = psel;
    w[9:8] = 2'(pre); w[6:0] = 7'(dv);
    return w;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write(input logic [15:0] w);
    wr_en = 1'b1; wr_data = w;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // returns at the first high sample of a period
  task automatic wait_rise(input string req);
    int k = 0;
    while (clk_out && k < 5000) begin @(negedge clk); k++; end
    while (!clk_out && k < 5000) begin @(negedge clk); k++; end
    if (k >= 5000) chk(req, "rise timeout", 0, 1);
  endtask

  // called at a first high sample; returns at the next one
  task automatic measure(output int hi, output int per);
    int lo = 0;
    hi = 1;
    forever begin
      @(negedge clk);
      if (!clk_out || hi > 5000) break;
      hi++;
    end
    lo = 1;
    forever begin
      @(negedge clk);
      if (clk_out || lo > 5000) break;
      lo++;
    end
    per = hi + lo;
  endtask

  task automatic stays_low(input string req, input int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (clk_out) seen++; end
    chk(req, "high samples while held", seen, 0);
  endtask

  // ratio in half source cycles: code1=4, code2=5, code3=6
  task automatic t_period(input string req, input logic esel, input logic psel, input int pre,
                          input int dv, input int stride);
    int hi, per, half;
    half = (pre == 1) ? 4 : (pre == 2) ? 5 : 6;
    write(word(1'b1, esel, psel, pre, dv));
    chk(req, "cfg_valid", int'(cfg_valid), 1);
    wait_rise(req); wait_rise(req);
    measure(hi, per);
    chk(req, "period", per, dv * half * stride);
    chk(req, "high time", hi, (dv / 2) * half * stride);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "clk_out after reset", int'(clk_out), 0);
    chk("R1", "cfg_valid after reset", int'(cfg_valid), 0);
  endtask

  task automatic t_boundary();
    int hi, per;
    write(word(1'b1, 1'b0, 1'b0, 1, 3));
    wait_rise("R7"); wait_rise("R7");
    wr_en = 1'b1; wr_data = word(1'b1, 1'b0, 1'b0, 3, 6);
    measure(hi, per);
    wr_en = 1'b0;
    chk("R7", "old period kept", per, 12);
    chk("R7", "old high kept", hi, 4);
    measure(hi, per);
    chk("R7", "new period", per, 36);
    chk("R7", "new high", hi, 18);
  endtask

  task automatic t_disable();
    int hi, per;
    write(word(1'b1, 1'b0, 1'b0, 2, 8));
    wait_rise("R8"); wait_rise("R8");
    wr_en = 1'b1; wr_data = word(1'b0, 1'b0, 1'b0, 2, 8);
    measure(hi, per);
    wr_en = 1'b0;
    chk("R8", "high phase completes", hi, 20);
    chk("R8", "valid while disabled", int'(cfg_valid), 1);
    stays_low("R8", 200);
  endtask

  task automatic t_invalid();
    int hi, per;
    write(word(1'b1, 1'b0, 1'b0, 1, 4));
    wait_rise("R6"); wait_rise("R6");
    wr_en = 1'b1; wr_data = word(1'b1, 1'b0, 1'b0, 1, 1);
    measure(hi, per);
    wr_en = 1'b0;
    chk("R6", "high phase completes", hi, 8);
    chk("R6", "cfg_valid div=1", int'(cfg_valid), 0);
    stays_low("R6", 200);
    write(word(1'b1, 1'b0, 1'b0, 0, 10));
    chk("R6", "cfg_valid code=0", int'(cfg_valid), 0);
    stays_low("R6", 200);
    write(word(1'b1, 1'b1, 1'b1, 3, 0));
    chk("R6", "cfg_valid div=0", int'(cfg_valid), 0);
    stays_low("R6", 200);
  endtask

  task automatic t_replace();
    int hi, per;
    write(word(1'b1, 1'b1, 1'b1, 1, 9));
    wait_rise("R2");
    write(word(1'b1, 1'b0, 1'b0, 3, 2));
    wait_rise("R2"); wait_rise("R2");
    measure(hi, per);
    chk("R2", "period after full replace", per, 12);
    chk("R2", "high after full replace", hi, 6);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_period("R4", 1'b0, 1'b0, 1, 2, 1);
    t_period("R4", 1'b0, 1'b0, 2, 4, 1);
    t_period("R5", 1'b1, 1'b0, 3, 5, 2);
    t_period("R10", 1'b1, 1'b1, 2, 127, 3);
    t_period("R3", 1'b0, 1'b1, 1, 3, 1);
    t_period("R3", 1'b1, 1'b1, 1, 2, 3);
    t_boundary();
    t_disable();
    t_invalid();
    t_replace();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule